// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a per-core countdown timer behind a word-wide register bus. Software sets a start value, picks a prescale ratio and turns the timer on. The counter then steps down by one after every P+1 clock cycles. When the count runs out, a sticky status bit is raised, and that bit drives a level interrupt line.

In auto-reload mode the counter refills from the start value at each expiry and keeps running, which gives a periodic interrupt. Without auto-reload it stays at zero until software writes a new value. A counter that holds zero never runs and never fires, even while the timer is enabled.

The status bit is cleared by writing a one to it. Only full-word accesses to the four defined offsets in a 32-byte window have any effect.

Top module: `reload_timer`

## Requirements
- R1: After reset, load, counter, control and status all read zero and `irq` is low.
- R2: The register offsets are: 0x00 load, 0x04 counter, 0x08 control, 0x0C status. In control, bit 0 is enable, bit 1 is auto-reload and bits 15:8 are the prescale value P. The other control bits read zero. Status is bit 0 at 0x0C.
- R3: While the timer is enabled and the counter is nonzero, the counter drops by one every P+1 cycles. The first drop comes P+1 cycles after the enable rising edge or after any counter write. While the timer is disabled, the counter holds its value.
- R4: A write to 0x00 sets both the load register and the counter. A write to 0x04 sets only the counter, and the load register keeps its value.
- R5: Expiry happens when the counter is 1 at the end of a prescale period. In that same cycle the counter takes its next value, and the status bit becomes 1 one cycle later. Without auto-reload, the next value is 0 and the counter stays there.
- R6: With auto-reload set, expiry refills the counter from the load register and counting carries on.
- R7: If enable goes from 0 to 1 while the counter is zero and auto-reload is set in the same write, the counter first takes the load value.
- R8: A zero counter never counts and never expires, even while enabled.
- R9: Reading 0x04 returns 0 when the timer is disabled or the counter is zero. Otherwise it returns the remaining count.
- R10: Writing 1 to status bit 0 clears the bit, and writing 0 leaves it unchanged. If an expiry sets the bit in the same cycle as a clear, the set wins. `irq` always equals the status bit.
- R11: Unmapped offsets read zero and ignore writes. An access whose byte enables are not all ones is ignored on writes and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the window |
| bus_be | input | 4 | Byte enables; all ones required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| irq | output | 1 | Level interrupt, equal to the status bit |

## Verification
The hardest case to reach is an expiry that lands in the same cycle as a status clear. To force it, the stimulus uses auto-reload with load value 1 and P = 0, so the timer expires on every cycle. A clear write during that window must then leave `irq` high. Writes to the counter in the middle of a prescale period also need care, because they restart the period. The bench model predicts the counter value and `irq` on every edge, so a period off by one cycle shows up at once.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
   localparam int OFF_LOAD = 'h00;
   localparam int OFF_CNT  = 'h04;
   localparam int OFF_CTRL = 'h08;
   localparam int OFF_STAT = 'h0C;
   localparam int CB_EN    = 0;
   localparam int CB_AR    = 1;
   localparam int CB_PRESC = 8;
endpackage

// File: rtl/rt_regs.sv
module rt_regs
   import reload_timer_pkg::*;
#(
   parameter int DW  = 32,
   parameter int PW  = 8,
   parameter int AW  = 5,
   localparam int BW  = DW / 8,
   localparam int PWX = (PW > 0) ? PW : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [BW-1:0] be,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] cnt,
   input  logic          exp_q,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] load_q,
   output logic          en_q,
   output logic          ar_q,
   output logic [PWX-1:0] presc_q,
   output logic          status_q,
   output logic          wr_load,
   output logic          wr_cnt,
   output logic          fetch,
   output logic          any_wr,
   output logic          stat_clr
);
   logic acc, wr_ctrl, wr_stat, en_rise;

   assign acc      = sel && (be == {BW{1'b1}});
   assign any_wr   = acc && wr;
   assign wr_load  = any_wr && (addr == AW'(OFF_LOAD));
   assign wr_cnt   = any_wr && (addr == AW'(OFF_CNT));
   assign wr_ctrl  = any_wr && (addr == AW'(OFF_CTRL));
   assign wr_stat  = any_wr && (addr == AW'(OFF_STAT));
   assign en_rise  = wr_ctrl && wdata[CB_EN] && !en_q;
   assign fetch    = en_rise && wdata[CB_AR];
   assign stat_clr = wr_stat && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q   <= '0;
         en_q     <= 1'b0;
         ar_q     <= 1'b0;
         status_q <= 1'b0;
      end else begin
         if (wr_load) load_q <= wdata;
         if (wr_ctrl) begin
            en_q <= wdata[CB_EN];
            ar_q <= wdata[CB_AR];
         end
         if (exp_q)         status_q <= 1'b1;
         else if (stat_clr) status_q <= 1'b0;
      end
   end

   logic [DW-1:0] ctrl_rd;
   generate
      if (PW > 0) begin : g_presc_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       presc_q <= '0;
            else if (wr_ctrl) presc_q <= wdata[CB_PRESC +: PW];
         end
         always_comb begin
            ctrl_rd = '0;
            ctrl_rd[CB_EN] = en_q;
            ctrl_rd[CB_AR] = ar_q;
            ctrl_rd[CB_PRESC +: PW] = presc_q;
         end
      end else begin : g_no_presc
         assign presc_q = '0;
         always_comb begin
            ctrl_rd = '0;
            ctrl_rd[CB_EN] = en_q;
            ctrl_rd[CB_AR] = ar_q;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (acc && !wr) begin
         case (addr)
            AW'(OFF_LOAD): rdata = load_q;
            AW'(OFF_CNT):  rdata = (en_q && cnt != '0) ? cnt : '0;
            AW'(OFF_CTRL): rdata = ctrl_rd;
            AW'(OFF_STAT): rdata = {{(DW-1){1'b0}}, status_q};
            default:       rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/rt_prescale.sv
module rt_prescale #(
   parameter int PW  = 8,
   localparam int PWX = (PW > 0) ? PW : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           restart,
   input  logic [PWX-1:0] presc,
   output logic           tick
);
   generate
      if (PW > 0) begin : g_div
         logic [PW-1:0] pcnt_q;
         assign tick = run && (pcnt_q >= presc);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         pcnt_q <= '0;
            else if (restart || !run || tick)   pcnt_q <= '0;
            else                                pcnt_q <= pcnt_q + 1'b1;
         end
      end else begin : g_bypass
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/rt_core.sv
module rt_core #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_any_cnt,
   input  logic [DW-1:0] wdata,
   input  logic          fetch,
   input  logic          ar,
   input  logic [DW-1:0] load,
   input  logic          tick,
   output logic [DW-1:0] cnt_q,
   output logic          exp_q
);
   localparam logic [DW-1:0] ONE = DW'(1);
   logic expire_now;

   assign expire_now = tick && (cnt_q == ONE) && !wr_any_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= expire_now;
         if (wr_any_cnt)                    cnt_q <= wdata;
         else if (fetch && cnt_q == '0)     cnt_q <= load;
         else if (expire_now)               cnt_q <= ar ? load : '0;
         else if (tick)                     cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
   parameter int DW = 32,
   parameter int PW = 8,
   parameter int AW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW/8-1:0] bus_be,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   output logic            irq
);
   localparam int PWX = (PW > 0) ? PW : 1;

   generate
      if (DW < 16 || DW % 8 != 0) begin : g_bad_dw
         $error("reload_timer: DW must be a multiple of 8 and at least 16");
      end
      if (PW < 0 || PW > 8) begin : g_bad_pw
         $error("reload_timer: PW must lie in 0..8");
      end
      if (AW < 4) begin : g_bad_aw
         $error("reload_timer: AW must cover offset 0x0C");
      end
   endgenerate

   logic [DW-1:0]  load_q, cnt_q;
   logic [PWX-1:0] presc_q;
   logic en_q, ar_q, status_q, exp_q, tick;
   logic wr_load, wr_cnt, fetch, any_wr, stat_clr, restart, run;

   rt_regs #(.DW(DW), .PW(PW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .be(bus_be), .wdata(bus_wdata), .cnt(cnt_q), .exp_q(exp_q),
      .rdata(bus_rdata), .load_q(load_q), .en_q(en_q), .ar_q(ar_q),
      .presc_q(presc_q), .status_q(status_q), .wr_load(wr_load),
      .wr_cnt(wr_cnt), .fetch(fetch), .any_wr(any_wr), .stat_clr(stat_clr)
   );

   assign run     = en_q && (cnt_q != '0);
   assign restart = wr_load || wr_cnt || fetch;

   rt_prescale #(.PW(PW)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .presc(presc_q), .tick(tick)
   );

   rt_core #(.DW(DW)) u_core (
      .clk(clk), .rst_n(rst_n), .wr_any_cnt(wr_load || wr_cnt),
      .wdata(bus_wdata), .fetch(fetch), .ar(ar_q), .load(load_q),
      .tick(tick), .cnt_q(cnt_q), .exp_q(exp_q)
   );

   assign irq = status_q;
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          exp_q,
   input logic          status,
   input logic [DW-1:0] cnt,
   input logic          en,
   input logic          any_wr,
   input logic          stat_clr
);
   AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |=> status); // R5

   AST_ZERO_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |=> !exp_q); // R8

   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !any_wr) |=> $stable(cnt)); // R3

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !exp_q) |=> !status); // R10
endmodule

bind reload_timer reload_timer_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .exp_q(exp_q), .status(status_q), .cnt(cnt_q),
   .en(en_q), .any_wr(any_wr), .stat_clr(stat_clr)
);

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0, errors = 0, cycles = 0;

   always #4 clk = ~clk;

   reload_timer u_reload_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference state
   longint m_load, m_cnt, m_p, m_presc;
   bit     m_en, m_ar, m_stat, m_exp;

   function automatic longint model_read(int a, bit [3:0] be);
      if (be != 4'hF) return 0;
      case (a)
         0:  return m_load;
         4:  return (m_en && m_cnt != 0) ? m_cnt : 0;
         8:  return (m_presc << 8) | (longint'(m_ar) << 1) | longint'(m_en);
         12: return longint'(m_stat);
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_load = 0; m_cnt = 0; m_p = 0; m_presc = 0;
         m_en = 0; m_ar = 0; m_stat = 0; m_exp = 0;
      end else begin
         bit ok, wl, wc, wctl, ws, rise, fet, run, tk, nexp;
         longint wd;
         ok   = bus_sel && bus_wr && bus_be == 4'hF;
         wd   = longint'(bus_wdata);
         wl   = ok && bus_addr == 0;
         wc   = ok && bus_addr == 4;
         wctl = ok && bus_addr == 8;
         ws   = ok && bus_addr == 12;
         rise = wctl && bus_wdata[0] && !m_en;
         fet  = rise && bus_wdata[1];
         run  = m_en && m_cnt != 0;
         tk   = run && m_p >= m_presc;
         nexp = tk && m_cnt == 1 && !(wl || wc);
         // status uses the previous expiry flag
         if (m_exp) m_stat = 1;
         else if (ws && bus_wdata[0]) m_stat = 0;
         m_exp = nexp;
         m_p = (wl || wc || fet || !run || tk) ? 0 : m_p + 1;
         if (wl || wc)                m_cnt = wd;
         else if (fet && m_cnt == 0)  m_cnt = m_load;
         else if (nexp)               m_cnt = m_ar ? m_load : 0;
         else if (tk)                 m_cnt = m_cnt - 1;
         if (wl) m_load = wd;
         if (wctl) begin
            m_en = bus_wdata[0]; m_ar = bus_wdata[1];
            m_presc = longint'(bus_wdata[15:8]);
         end
      end
   end

   task automatic chk(longint act, longint exp, string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // irq compared with the model after every edge (R10)
   always @(posedge clk) begin
      #1;
      if (rst_n) chk(irq, m_stat, "R10 irq tracks status");
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_sel = 0; bus_wr = 0;
      end
   endtask

   task automatic wr(int a, longint d, bit [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 5'(a); bus_be = be; bus_wdata = 32'(d);
      @(posedge clk);
   endtask

   task automatic rd(int a, string tag, bit [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = 5'(a); bus_be = be;
      #1;
      chk(bus_rdata, model_read(a, be), tag);
      @(posedge clk);
   endtask

   task automatic rd_lit(int a, longint exp, string tag);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = 5'(a); bus_be = 4'hF;
      #1;
      chk(bus_rdata, exp, tag);
      @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1 reset state
      rd_lit(0, 0, "R1 load"); rd_lit(4, 0, "R1 counter");
      rd_lit(8, 0, "R1 control"); rd_lit(12, 0, "R1 status");
      chk(irq, 0, "R1 irq");

      // R2 control fields and R9 disabled read
      wr(8, 32'hFFFF_A5FE);
      rd_lit(8, 32'h0000_A502, "R2 control readback");
      wr(8, 0);
      wr(0, 4);
      rd_lit(0, 4, "R4 load write");
      rd_lit(4, 0, "R9 disabled counter reads 0");

      // R3 timing with P=1
      wr(8, 32'h0000_0101);
      rd_lit(4, 4, "R3 first cycle");
      rd_lit(4, 4, "R3 before period end");
      rd_lit(4, 3, "R3 first decrement");
      for (int i = 0; i < 8; i++) rd(4, "R3 counting");
      rd_lit(4, 0, "R5 holds zero");
      rd_lit(12, 1, "R5 status set");
      idle(5);
      rd_lit(4, 0, "R5 still zero");
      wr(12, 0);
      rd_lit(12, 1, "R10 write 0 keeps status");
      wr(12, 1);
      rd_lit(12, 0, "R10 clear");

      // R4 counter write leaves load
      wr(4, 9);
      rd_lit(0, 4, "R4 counter write keeps load");
      rd(4, "R4 counter write");
      for (int i = 0; i < 12; i++) rd(4, "R3 after restart");
      // restart mid period (R3)
      wr(4, 3);
      for (int i = 0; i < 10; i++) rd(4, "R3 restart mid period");
      wr(12, 1);

      // R8 zero counter enabled never expires
      wr(8, 0); wr(4, 0); wr(8, 32'h0000_0001);
      idle(40);
      rd_lit(12, 0, "R8 no expiry at zero");
      rd_lit(4, 0, "R9 zero counter reads 0");

      // R7 fetch on enable rise with auto-reload
      wr(8, 0); wr(0, 6); wr(4, 0);
      wr(8, 32'h0000_0203);
      rd_lit(4, 6, "R7 fetched load");
      // R6 periodic reload
      for (int i = 0; i < 60; i++) rd(4, "R6 auto reload");
      rd_lit(12, 1, "R6 expired");
      wr(12, 1);
      for (int i = 0; i < 30; i++) rd(4, "R6 continues");

      // R10 set beats clear: expiry every cycle
      wr(8, 0); wr(0, 1); wr(8, 32'h0000_0003);
      idle(4);
      wr(12, 1);
      rd_lit(12, 1, "R10 set wins over clear");
      wr(8, 0);
      idle(3);
      wr(12, 1);
      rd_lit(12, 0, "R10 clear after stop");

      // R11 unmapped and partial accesses
      wr(16, 32'hDEAD_BEEF);
      rd_lit(16, 0, "R11 unmapped read");
      rd_lit(0, 1, "R11 unmapped write ignored");
      wr(0, 32'h77, 4'h3);
      rd_lit(0, 1, "R11 partial write ignored");
      rd(0, "R11 partial read", 4'h1);
      wr(2, 5);
      rd_lit(0, 1, "R11 misaligned write ignored");

      idle(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule